// File: doc/BRIEF.md
# Framed Serial Slave Port with Frame-Sync Role Select

This block is a serial port that always takes its bit clock from outside and moves 16-bit words in framed form. The bit clock runs without pause. A word boundary is marked by a frame-sync pulse that lasts one bit-clock period. A role input decides who produces that pulse. In the sync-source role the port drives the pulse itself whenever software places a word in its transmit buffer. In the sync-follower role it waits for a pulse that another device drives. All logic runs on a system clock. The serial clock, data input and frame-sync input are synchronized into that clock domain, and their edges are detected there. Each serial-clock phase must therefore last at least three system clocks.

Data leaves most-significant bit first and changes on the falling edge of the serial clock. Incoming data is sampled on the rising edge. When a word is complete, it is copied to a receive buffer and a full flag is raised. The shifter then waits for the next frame start. The frame-sync pin is bidirectional and is modelled as a separate input, output and output enable.

Top module: `fspi_slave`

## Requirements
- R1: The port works only while `en_i`=1, `master_en_i`=0 and `framed_en_i`=1. In any other case it holds idle: `sdo_o`=0, `fs_o`=0 and `fs_oe_o`=0, and a write to the transmit buffer is discarded, so no frame is started later because of it.
- R2: `fs_oe_o` is 1 exactly when the port works and `fs_role_i`=0 (sync-source role). With `fs_role_i`=1 (sync-follower role) the frame-sync pin is only an input.
- R3: In the sync-source role, a write (`tx_wr_i`=1 for one clock) makes `fs_o` go high at the next falling serial-clock edge. It stays high for exactly one serial-clock period and falls at the following falling edge.
- R4: The written word's bit 15 appears on `sdo_o` at the same falling edge that starts the frame. Bits 14 down to 0 follow, one per later falling edge, and `sdo_o` changes at no other time.
- R5: In the sync-follower role, `fs_i` (active high) is sampled on rising serial-clock edges while idle. After it is seen high, shifting starts at the next falling edge.
- R6: `sdi_i` is sampled on the 16 rising edges of a frame and assembled first-bit-as-MSB. After the 16th sample, the word appears on `rx_data_o` and `rx_full_o` goes to 1.
- R7: A one-clock `rx_rd_i` pulse clears `rx_full_o`. If a word completes in the same clock, the flag stays set.
- R8: If a frame starts in the sync-follower role with no pending write, the port sends sixteen zeros and still receives the word.
- R9: In the sync-source role, a write made while a frame is in progress is held. It starts a new frame-sync pulse at the first falling edge after that frame ends.
- R10: After a frame ends, no further frame-sync pulse is produced in the sync-source role until a new write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Port enable |
| master_en_i | input | 1 | Clock-master setting; must be 0 for operation |
| framed_en_i | input | 1 | Framed operation setting; must be 1 for operation |
| fs_role_i | input | 1 | 0: port drives frame sync, 1: port receives frame sync |
| tx_data_i | input | 16 | Word to transmit |
| tx_wr_i | input | 1 | Transmit buffer write strobe |
| rx_data_o | output | 16 | Last received word |
| rx_full_o | output | 1 | Receive buffer holds an unread word |
| rx_rd_i | input | 1 | Receive buffer read strobe, clears the full flag |
| sclk_i | input | 1 | External serial clock, free running |
| sdi_i | input | 1 | Serial data in |
| sdo_o | output | 1 | Serial data out |
| fs_i | input | 1 | Frame-sync pin input |
| fs_o | output | 1 | Frame-sync pin output |
| fs_oe_o | output | 1 | Frame-sync pin output enable |

## Verification
The bench measures the frame-sync pulse width in system clocks. A design whose pulse ends on the wrong edge would show a count other than one serial-clock period. It writes a second word in the middle of a sync-source frame. A design that drops the write, or restarts at once, would send one word or a corrupted word instead of two in order. It runs a sync-follower frame with no write, and a design that resent stale data would put a non-zero word on `sdo_o`. It also disables the port through the clock-master setting and then writes. A design that only gated the output enable would still toggle `sdo_o`, or would start a frame after it is re-enabled.

// File: rtl/fspi_pkg.sv
package fspi_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_SHIFT = 2'd2
    } fspi_state_e;

endpackage

// File: rtl/fspi_edge.sv
module fspi_edge #(
    parameter int STAGES = 2,
    parameter int N      = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] raw_i,
    output logic [N-1:0] sync_o,
    output logic         rise_o,
    output logic         fall_o
);

    typedef struct packed {
        logic [STAGES-1:0][N-1:0] pipe;
        logic                     prev;
    } edge_t;

    edge_t d, q;

    always_comb begin
        d = q;
        d.pipe[0] = raw_i;
        for (int i = 1; i < STAGES; i++) begin
            d.pipe[i] = q.pipe[i-1];
        end
        d.prev = q.pipe[STAGES-1][0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sync_o = q.pipe[STAGES-1];
    assign rise_o = q.pipe[STAGES-1][0] & ~q.prev;
    assign fall_o = ~q.pipe[STAGES-1][0] & q.prev;

endmodule

// File: rtl/fspi_shifter.sv
module fspi_shifter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    input  logic         shift_i,
    input  logic         sample_i,
    input  logic         sdi_i,
    output logic         msb_o,
    output logic         last_o,
    output logic [W-1:0] rx_next_o
);

    localparam int CW = (W > 1) ? $clog2(W) : 1;
    localparam logic [CW-1:0] LAST_IDX = CW'(W - 1);

    typedef struct packed {
        logic [W-1:0]  tx;
        logic [W-1:0]  rx;
        logic [CW-1:0] cnt;
    } sh_t;

    sh_t d, q;

    always_comb begin
        d         = q;
        rx_next_o = {q.rx[W-2:0], sdi_i};
        last_o    = sample_i && (q.cnt == LAST_IDX);
        if (load_i) begin
            d.tx  = load_val_i;
            d.cnt = '0;
        end else if (shift_i) begin
            d.tx = {q.tx[W-2:0], 1'b0};
        end
        if (sample_i && !load_i) begin
            d.rx  = rx_next_o;
            d.cnt = last_o ? '0 : q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign msb_o = q.tx[W-1];

    // R6: each sample moves the bit count on by one until the word is full
    p_count_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_i && !load_i && q.cnt != LAST_IDX) |=> (q.cnt == $past(q.cnt) + 1'b1));

endmodule

// File: rtl/fspi_slave.sv
module fspi_slave #(
    parameter int W           = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en_i,
    input  logic         master_en_i,
    input  logic         framed_en_i,
    input  logic         fs_role_i,
    input  logic [W-1:0] tx_data_i,
    input  logic         tx_wr_i,
    output logic [W-1:0] rx_data_o,
    output logic         rx_full_o,
    input  logic         rx_rd_i,
    input  logic         sclk_i,
    input  logic         sdi_i,
    output logic         sdo_o,
    input  logic         fs_i,
    output logic         fs_o,
    output logic         fs_oe_o
);

    import fspi_pkg::*;

    localparam int PINS = 3;

    typedef struct packed {
        fspi_state_e  st;
        logic [W-1:0] txb;
        logic         pend;
        logic         fs;
        logic [W-1:0] rxb;
        logic         full;
    } ctl_t;

    ctl_t d, q;

    logic [PINS-1:0] pins_s;
    logic            sclk_rise, sclk_fall;
    logic            active;
    logic            load, shift_en, sample_en, last, tx_msb;
    logic [W-1:0]    load_val, rx_next;

    fspi_edge #(.STAGES(SYNC_STAGES), .N(PINS)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  ({fs_i, sdi_i, sclk_i}),
        .sync_o (pins_s),
        .rise_o (sclk_rise),
        .fall_o (sclk_fall)
    );

    assign active    = en_i && !master_en_i && framed_en_i;
    assign shift_en  = sclk_fall && (q.st == ST_SHIFT);
    assign sample_en = sclk_rise && (q.st == ST_SHIFT);

    fspi_shifter #(.W(W)) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (load),
        .load_val_i (load_val),
        .shift_i    (shift_en),
        .sample_i   (sample_en),
        .sdi_i      (pins_s[1]),
        .msb_o      (tx_msb),
        .last_o     (last),
        .rx_next_o  (rx_next)
    );

    always_comb begin
        d        = q;
        load     = 1'b0;
        load_val = q.pend ? q.txb : '0;
        if (rx_rd_i)   d.full = 1'b0;
        if (sclk_fall) d.fs   = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (!fs_role_i) begin
                    if (sclk_fall && q.pend) begin
                        load   = 1'b1;
                        d.pend = 1'b0;
                        d.fs   = 1'b1;
                        d.st   = ST_SHIFT;
                    end
                end else if (sclk_rise && pins_s[2]) begin
                    d.st = ST_ARMED;
                end
            end
            ST_ARMED: begin
                if (sclk_fall) begin
                    load   = 1'b1;
                    d.pend = 1'b0;
                    d.st   = ST_SHIFT;
                end
            end
            ST_SHIFT: begin
                if (last) begin
                    d.rxb  = rx_next;
                    d.full = 1'b1;
                    d.st   = ST_IDLE;
                end
            end
            default: d.st = ST_IDLE;
        endcase
        if (tx_wr_i) begin
            d.txb  = tx_data_i;
            d.pend = 1'b1;
        end
        if (!active) begin
            d.st   = ST_IDLE;
            d.fs   = 1'b0;
            d.pend = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: ST_IDLE, default: '0};
        else        q <= d;
    end

    assign sdo_o     = (q.st == ST_SHIFT) ? tx_msb : 1'b0;
    assign fs_o      = q.fs;
    assign fs_oe_o   = active && !fs_role_i;
    assign rx_data_o = q.rxb;
    assign rx_full_o = q.full;

    // R1: leaving operation drops any frame and any sync pulse
    p_idle_when_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> (q.st == ST_IDLE && !fs_o));

    // R3: the sync pulse exists only inside a frame
    p_fs_in_frame_r3: assert property (@(posedge clk) disable iff (!rst_n)
        fs_o |-> (q.st == ST_SHIFT));

    // R3: the sync pulse lasts until the next falling serial edge
    p_fs_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (fs_o && active && !sclk_fall) |=> fs_o);

    // R4: serial output moves only on serial clock edges
    p_sdo_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !sclk_fall && !sclk_rise) |=> $stable(sdo_o));

    // R6: a completed word raises the full flag
    p_full_after_word_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (active && last) |=> rx_full_o);

    // R7: a read with no completing word clears the flag
    p_read_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_rd_i && !last) |=> !rx_full_o);

endmodule

// File: tb/test_fspi_slave.sv
module test_fspi_slave;

    localparam int CLK_PERIOD = 10;
    localparam int HALF_SCLK  = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0, men = 1'b0, fen = 1'b0, role = 1'b0;
    logic [15:0] tx_data = '0;
    logic        tx_wr = 1'b0, rx_rd = 1'b0;
    logic        sclk = 1'b0, sdi = 1'b0, fs_in = 1'b0;
    logic [15:0] rx_data;
    logic        rx_full, sdo, fs_out, fs_oe;

    int errors = 0;
    int checks = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fspi_slave i_fspi_slave (
        .clk (clk), .rst_n (rst_n), .en_i (en), .master_en_i (men),
        .framed_en_i (fen), .fs_role_i (role), .tx_data_i (tx_data),
        .tx_wr_i (tx_wr), .rx_data_o (rx_data), .rx_full_o (rx_full),
        .rx_rd_i (rx_rd), .sclk_i (sclk), .sdi_i (sdi), .sdo_o (sdo),
        .fs_i (fs_in), .fs_o (fs_out), .fs_oe_o (fs_oe)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    logic [2:0]  hk, hd, hf;
    int          ms, nb;
    logic [15:0] m_txs, m_rxs, m_txb, m_rxb;
    logic        m_pend, m_fs, m_full;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hk = '0; hd = '0; hf = '0; ms = 0; nb = 0;
            m_txs = '0; m_rxs = '0; m_txb = '0; m_rxb = '0;
            m_pend = 0; m_fs = 0; m_full = 0;
        end else begin
            bit rise, fall, act;
            int s0;
            rise = hk[1] && !hk[2];
            fall = !hk[1] && hk[2];
            act  = en && !men && fen;
            s0   = ms;
            if (rx_rd) m_full = 0;
            if (fall)  m_fs = 0;
            if (s0 == 2) begin
                if (fall) m_txs = m_txs << 1;
                if (rise) begin
                    m_rxs = {m_rxs[14:0], hd[1]};
                    nb++;
                    if (nb == 16) begin m_rxb = m_rxs; m_full = 1; ms = 0; end
                end
            end else if (s0 == 1) begin
                if (fall) begin m_txs = m_pend ? m_txb : 16'h0; m_pend = 0; nb = 0; ms = 2; end
            end else if (!role) begin
                if (fall && m_pend) begin m_txs = m_txb; m_pend = 0; nb = 0; m_fs = 1; ms = 2; end
            end else if (rise && hf[1]) begin
                ms = 1;
            end
            if (tx_wr) begin m_txb = tx_data; m_pend = 1; end
            if (!act) begin ms = 0; m_fs = 0; m_pend = 0; end
            hk = {hk[1:0], sclk};
            hd = {hd[1:0], sdi};
            hf = {hf[1:0], fs_in};
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            chk("R4 model sdo", int'(sdo), (ms == 2) ? int'(m_txs[15]) : 0);
            chk("R3 model fs_o", int'(fs_out), int'(m_fs));
            chk("R2 model fs_oe", int'(fs_oe), int'(en && !men && fen && !role));
            chk("R6 model rx_data", int'(rx_data), int'(m_rxb));
            chk("R7 model rx_full", int'(rx_full), int'(m_full));
        end
    end

    // ---------------- monitors ----------------
    int   fs_rises = 0, fs_hi = 0, sdo_hi = 0;
    logic fs_prev = 1'b0;
    always @(negedge clk) begin
        if (fs_out && !fs_prev) fs_rises++;
        if (fs_out) fs_hi++;
        if (sdo) sdo_hi++;
        fs_prev = fs_out;
    end

    // ---------------- serial clock and far-end device ----------------
    int          fph = 0, dbits = 0, cap = 0;
    logic [15:0] mword = '0, drv = '0, capw = '0;
    logic [15:0] capq[$];

    initial begin
        @(posedge rst_n);
        forever begin
            repeat (HALF_SCLK) @(negedge clk);
            if (sclk == 1'b0) begin
                sclk = 1'b1;
                if (cap > 0) begin
                    capw = {capw[14:0], sdo};
                    cap--;
                    if (cap == 0) capq.push_back(capw);
                end else if (fs_out && fs_oe) begin
                    capw = {15'h0, sdo};
                    cap = 15;
                end
            end else begin
                sclk = 1'b0;
                if (fph == 1) begin
                    fs_in = 1'b1; fph = 2;
                end else if (fph == 2) begin
                    fs_in = 1'b0; fph = 0; drv = mword; dbits = 16; cap = 16;
                end
                if (dbits > 0) begin
                    sdi = drv[15]; drv = drv << 1; dbits--;
                end else begin
                    sdi = 1'b0;
                end
            end
        end
    end

    task automatic write_tx(input logic [15:0] v);
        @(negedge clk); tx_data = v; tx_wr = 1'b1;
        @(negedge clk); tx_wr = 1'b0;
    endtask

    task automatic wait_words(input int n);
        for (int i = 0; i < 5000 && capq.size() < n; i++) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset sdo", int'(sdo), 0);
        chk("R1 reset fs_oe", int'(fs_oe), 0);
        chk("R6 reset rx_full", int'(rx_full), 0);
        rst_n = 1'b1;
        repeat (10) @(negedge clk);

        // sync-follower role: written word goes out, incoming word lands
        en = 1; men = 0; fen = 1; role = 1;
        @(negedge clk);
        chk("R2 follower fs_oe", int'(fs_oe), 0);
        write_tx(16'hA5C3);
        mword = 16'h3C96; fph = 1;
        wait_words(1);
        chk("R5 follower tx word", int'(capq.size() > 0 ? capq[0] : 16'hDEAD), 16'hA5C3);
        repeat (8) @(negedge clk);
        chk("R6 rx word", int'(rx_data), 16'h3C96);
        chk("R6 rx_full set", int'(rx_full), 1);
        @(negedge clk); rx_rd = 1'b1;
        @(negedge clk); rx_rd = 1'b0;
        chk("R7 read clears", int'(rx_full), 0);

        // follower frame with nothing written: zeros out
        capq.delete();
        repeat (20) @(negedge clk);
        mword = 16'h1234; fph = 1;
        wait_words(1);
        chk("R8 zeros sent", int'(capq.size() > 0 ? capq[0] : 16'hDEAD), 0);
        repeat (8) @(negedge clk);
        chk("R8 rx still received", int'(rx_data), 16'h1234);

        // sync-source role
        repeat (40) @(negedge clk);
        role = 0; capq.delete();
        @(negedge clk);
        chk("R2 source fs_oe", int'(fs_oe), 1);
        fs_hi = 0; fs_rises = 0;
        write_tx(16'hBEEF);
        wait_words(1);
        chk("R4 source tx word", int'(capq.size() > 0 ? capq[0] : 16'hDEAD), 16'hBEEF);
        chk("R3 pulse width", fs_hi, 2 * HALF_SCLK);
        chk("R3 one pulse", fs_rises, 1);
        fs_rises = 0;
        repeat (400) @(negedge clk);
        chk("R10 no pulse without write", fs_rises, 0);

        // write held while a frame runs
        capq.delete(); fs_rises = 0;
        write_tx(16'h1111);
        for (int i = 0; i < 200 && !fs_out; i++) @(negedge clk);
        repeat (20) @(negedge clk);
        write_tx(16'h2222);
        wait_words(2);
        chk("R9 first word", int'(capq.size() > 0 ? capq[0] : 16'hDEAD), 16'h1111);
        chk("R9 held word", int'(capq.size() > 1 ? capq[1] : 16'hDEAD), 16'h2222);
        chk("R9 two pulses", fs_rises, 2);

        // disabled through clock-master setting
        repeat (40) @(negedge clk);
        men = 1; fs_rises = 0; sdo_hi = 0;
        @(negedge clk);
        chk("R1 off fs_oe", int'(fs_oe), 0);
        write_tx(16'h7777);
        repeat (400) @(negedge clk);
        chk("R1 off no pulse", fs_rises, 0);
        chk("R1 off sdo quiet", sdo_hi, 0);
        men = 0;
        repeat (400) @(negedge clk);
        chk("R1 discarded write", fs_rises, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule